// File: doc/BRIEF.md
# Dual-Register DDS Waveform Core

This block is a numerically controlled oscillator clocked by the master clock. A 28-bit phase accumulator adds one of two frequency tuning words on every clock. The resulting output frequency is `word × f_clk / 2^28`. The top 12 accumulator bits, offset by one of two 12-bit phase words (one step is 2π/4096 rad), address a waveform shaper. The shaper produces either a sine sample from a quarter-wave table or a folded triangle. A separate square output is taken from the accumulator's top bit, either directly or divided by two.

Control comes as plain level inputs from a register decoder elsewhere:
- a generation hold;
- the frequency and phase register selects;
- the triangle mode;
- the square enable;
- the square-direct option.

The selects can change at any time. The accumulator is never cleared by a select change, so switching keeps phase continuity. Enabling triangle and square together is a reserved setting and produces no waveform.

Top module: `dds_wave_core`

## Requirements
- R1: While running, the accumulator advances by the selected tuning word on every clock, modulo 2^28; the shaper samples the accumulator value held before that edge, so `wave_sample` lags the accumulator by one clock.
- R2: `fsel_i` = 0 selects `ftw0_i` and 1 selects `ftw1_i`; a change applies at the next clock edge without clearing the accumulator.
- R3: `psel_i` = 0 selects `poff0_i` and 1 selects `poff1_i`; the selected offset is added modulo 4096 to accumulator bits [27:16] to form the phase index p.
- R4: While `hold_i` is 1 the accumulator is forced to zero and, one clock later, `wave_sample` = 0, `sample_valid` = 0 and `sq_out` = 0; after release, generation restarts from phase zero.
- R5: With `tri_mode_i` = 0, a valid sample is 512 ± T[k]. T[k] = round(511·sin(π(k+0.5)/128)) for k = 0..63. Let quadrant q = p[11:10] and i = p[9:4]. Then k = i when q[0] = 0 and k = 63 − i when q[0] = 1. The sign is + when q[1] = 0 and − when q[1] = 1.
- R6: With `tri_mode_i` = 1 (square off), a valid sample is p[10:1] when p[11] = 0 and the bitwise inverse of p[10:1] when p[11] = 1.
- R7: With `sq_en_i` = 1 and `sq_direct_i` = 1, `sq_out` equals accumulator bit 27 as sampled one clock earlier.
- R8: With `sq_en_i` = 1 and `sq_direct_i` = 0, `sq_out` toggles once per rising edge of accumulator bit 27, giving half the top-bit frequency; the divider state clears during hold.
- R9: `tri_mode_i` = 1 together with `sq_en_i` = 1 is reserved: `wave_sample`, `sample_valid` and `sq_out` stay 0 while the accumulator keeps running.
- R10: A selected tuning word above 2^27 (half the clock rate) is invalid: the accumulator holds its value and all outputs are suppressed as in R4; exactly 2^27 is valid.
- R11: With `sq_en_i` = 0, `sq_out` is 0.
- R12: After `rst_n` is asserted low, all outputs are 0 and the accumulator is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ftw0_i | input | 28 | Frequency tuning word 0 |
| ftw1_i | input | 28 | Frequency tuning word 1 |
| poff0_i | input | 12 | Phase offset 0 |
| poff1_i | input | 12 | Phase offset 1 |
| hold_i | input | 1 | Generation hold (accumulator zeroed, outputs quiet) |
| fsel_i | input | 1 | Frequency word select |
| psel_i | input | 1 | Phase offset select |
| tri_mode_i | input | 1 | 1 = triangle, 0 = sine |
| sq_en_i | input | 1 | Square output enable |
| sq_direct_i | input | 1 | 1 = square follows the top bit, 0 = divided by two |
| wave_sample | output | 10 | Offset-binary waveform sample |
| sample_valid | output | 1 | Sample carries a waveform |
| sq_out | output | 1 | Square output |

## Verification
Two pairs of events can meet in one clock. A select change can fall on the same edge as a top-bit rising edge that drives the divide-by-two toggle. A hold release can fall on the same edge as a tuning-word change. The bench provokes both by flipping `fsel_i` and `psel_i` while square mode runs with a fast word, and by releasing hold in the same cycle a new word is applied. A behavioural model advances its own accumulator and divider on every clock. The sample, valid flag and square bit are compared each cycle, so a misordered update shows up as a one-cycle mismatch.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int DDS_ACC_W = 28;
  localparam int DDS_PH_W  = 12;
  localparam int DDS_AMP_W = 10;
  localparam int DDS_QT_AW = 6;

  typedef enum logic [1:0] {
    SHAPE_SINE = 2'd0,
    SHAPE_TRI  = 2'd1,
    SHAPE_OFF  = 2'd2
  } shape_e;

  typedef struct packed {
    logic hold;
    logic fsel;
    logic psel;
    logic tri_mode;
    logic sq_en;
    logic sq_direct;
  } dds_ctl_t;
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             fsel,
  input  logic [ACC_W-1:0] ftw_a,
  input  logic [ACC_W-1:0] ftw_b,
  output logic [ACC_W-1:0] acc_q,
  output logic [ACC_W-1:0] ftw_sel,
  output logic             ftw_bad
);
  localparam logic [ACC_W-1:0] HALF_RATE = ACC_W'(1) << (ACC_W-1);

  function automatic logic word_too_fast(input logic [ACC_W-1:0] w);
    return w > HALF_RATE;
  endfunction

  assign ftw_sel = fsel ? ftw_b : ftw_a;
  assign ftw_bad = word_too_fast(ftw_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (hold)     acc_q <= '0;
    else if (!ftw_bad) acc_q <= acc_q + ftw_sel;
  end
endmodule

// File: rtl/dds_shaper.sv
module dds_shaper #(
  parameter int PH_W  = 12,
  parameter int AMP_W = 10,
  parameter int QT_AW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  phase_idx,
  input  dds_pkg::shape_e  shape,
  output logic [AMP_W-1:0] sample_q,
  output logic             valid_q
);
  localparam int QN      = 1 << QT_AW;
  localparam int MAG_W   = AMP_W - 1;
  localparam int MAG_MAX = (1 << MAG_W) - 1;
  localparam logic [AMP_W-1:0] MID = AMP_W'(1) << MAG_W;
  localparam int IDX_AVAIL = PH_W - 2;

  typedef logic [MAG_W-1:0] qtab_t [QN];

  function automatic qtab_t mk_qtab();
    qtab_t t;
    real ang;
    for (int k = 0; k < QN; k++) begin
      ang  = 3.14159265358979 * (real'(k) + 0.5) / real'(2 * QN);
      t[k] = MAG_W'($rtoi(real'(MAG_MAX) * $sin(ang) + 0.5));
    end
    return t;
  endfunction

  localparam qtab_t QTAB = mk_qtab();

  function automatic logic [AMP_W-1:0] fold_tri(input logic [PH_W-1:0] p);
    logic [AMP_W-1:0] ramp;
    ramp = AMP_W'(p[PH_W-2:0] >> (PH_W - 1 - AMP_W));
    return p[PH_W-1] ? ~ramp : ramp;
  endfunction

  logic [QT_AW-1:0] q_idx;
  logic [QT_AW-1:0] q_addr;
  logic [MAG_W-1:0] q_mag;
  logic [1:0]       quad;
  logic [AMP_W-1:0] sine_val;
  logic [AMP_W-1:0] tri_val;

  assign quad = phase_idx[PH_W-1 -: 2];

  generate
    if (QT_AW == IDX_AVAIL) begin : g_full_idx
      assign q_idx = phase_idx[IDX_AVAIL-1:0];
    end else begin : g_trunc_idx
      assign q_idx = phase_idx[IDX_AVAIL-1 -: QT_AW];
    end
  endgenerate

  assign q_addr   = quad[0] ? ~q_idx : q_idx;
  assign q_mag    = QTAB[q_addr];
  assign sine_val = quad[1] ? (MID - AMP_W'(q_mag)) : (MID + AMP_W'(q_mag));
  assign tri_val  = fold_tri(phase_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      unique case (shape)
        dds_pkg::SHAPE_SINE: begin sample_q <= sine_val; valid_q <= 1'b1; end
        dds_pkg::SHAPE_TRI:  begin sample_q <= tri_val;  valid_q <= 1'b1; end
        default:             begin sample_q <= '0;       valid_q <= 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/dds_square.sv
module dds_square (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic msb,
  input  logic en,
  input  logic direct,
  input  logic quiet,
  output logic msb_rise,
  output logic sq_q
);
  logic msb_prev;
  logic half_tog;
  logic tog_next;

  assign msb_rise = msb & ~msb_prev;
  assign tog_next = half_tog ^ msb_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_prev <= 1'b0;
      half_tog <= 1'b0;
      sq_q     <= 1'b0;
    end else if (hold) begin
      msb_prev <= 1'b0;
      half_tog <= 1'b0;
      sq_q     <= 1'b0;
    end else begin
      msb_prev <= msb;
      half_tog <= tog_next;
      sq_q     <= (en && !quiet) ? (direct ? msb : tog_next) : 1'b0;
    end
  end
endmodule

// File: rtl/dds_wave_core.sv
module dds_wave_core #(
  parameter int ACC_W = dds_pkg::DDS_ACC_W,
  parameter int PH_W  = dds_pkg::DDS_PH_W,
  parameter int AMP_W = dds_pkg::DDS_AMP_W,
  parameter int QT_AW = dds_pkg::DDS_QT_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] ftw0_i,
  input  logic [ACC_W-1:0] ftw1_i,
  input  logic [PH_W-1:0]  poff0_i,
  input  logic [PH_W-1:0]  poff1_i,
  input  logic             hold_i,
  input  logic             fsel_i,
  input  logic             psel_i,
  input  logic             tri_mode_i,
  input  logic             sq_en_i,
  input  logic             sq_direct_i,
  output logic [AMP_W-1:0] wave_sample,
  output logic             sample_valid,
  output logic             sq_out
);
  dds_pkg::dds_ctl_t ctl;
  dds_pkg::shape_e   shape;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] ftw_sel;
  logic             ftw_bad;
  logic [PH_W-1:0]  poff_sel;
  logic [PH_W-1:0]  phase_idx;
  logic             acc_msb;
  logic             msb_rise;
  logic             gen_hold;
  logic             mode_reserved;
  logic             out_quiet;

  assign ctl = '{hold: hold_i, fsel: fsel_i, psel: psel_i,
                 tri_mode: tri_mode_i, sq_en: sq_en_i, sq_direct: sq_direct_i};

  assign gen_hold      = ctl.hold;
  assign mode_reserved = ctl.tri_mode & ctl.sq_en;
  assign out_quiet     = gen_hold | ftw_bad | mode_reserved;
  assign poff_sel      = ctl.psel ? poff1_i : poff0_i;
  assign phase_idx     = acc_q[ACC_W-1 -: PH_W] + poff_sel;
  assign acc_msb       = acc_q[ACC_W-1];
  assign shape = out_quiet    ? dds_pkg::SHAPE_OFF :
                 ctl.tri_mode ? dds_pkg::SHAPE_TRI : dds_pkg::SHAPE_SINE;

  dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .hold(gen_hold), .fsel(ctl.fsel),
    .ftw_a(ftw0_i), .ftw_b(ftw1_i),
    .acc_q(acc_q), .ftw_sel(ftw_sel), .ftw_bad(ftw_bad)
  );

  dds_shaper #(.PH_W(PH_W), .AMP_W(AMP_W), .QT_AW(QT_AW)) u_shape (
    .clk(clk), .rst_n(rst_n), .phase_idx(phase_idx), .shape(shape),
    .sample_q(wave_sample), .valid_q(sample_valid)
  );

  dds_square u_sq (
    .clk(clk), .rst_n(rst_n), .hold(gen_hold), .msb(acc_msb),
    .en(ctl.sq_en), .direct(ctl.sq_direct), .quiet(out_quiet),
    .msb_rise(msb_rise), .sq_q(sq_out)
  );
endmodule

// File: rtl/dds_wave_chk.sv
module dds_wave_chk #(
  parameter int ACC_W = 28,
  parameter int AMP_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] ftw_sel,
  input logic             ftw_bad,
  input logic             reserved,
  input logic             sq_en,
  input logic             sq_direct,
  input logic [AMP_W-1:0] wave_sample,
  input logic             sample_valid,
  input logic             sq_out
);
  // R1
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !ftw_bad) |=> (acc == $past(acc) + $past(ftw_sel)));

  // R4
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (acc == '0 && !sample_valid && wave_sample == '0 && !sq_out));

  // R9
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reserved |=> (!sample_valid && !sq_out));

  // R10
  bad_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ftw_bad && !hold) |=> ($stable(acc) && !sample_valid));

  // R7
  sq_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_en && sq_direct && !hold && !ftw_bad && !reserved) |=>
      (sq_out == $past(acc[ACC_W-1])));

  // R11
  sq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sq_en |=> !sq_out);
endmodule

bind dds_wave_core dds_wave_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(gen_hold), .acc(acc_q), .ftw_sel(ftw_sel),
  .ftw_bad(ftw_bad), .reserved(mode_reserved), .sq_en(sq_en_i),
  .sq_direct(sq_direct_i), .wave_sample(wave_sample),
  .sample_valid(sample_valid), .sq_out(sq_out)
);

// File: tb/sim_dds_wave_core.sv
module sim_dds_wave_core;
  localparam int CLK_PERIOD = 10;
  localparam longint MOD = 64'd1 << 28;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n;
  logic [27:0] ftw0, ftw1;
  logic [11:0] po0, po1;
  logic        hold, fsel, psel, tri_m, sq_en, sq_dir;
  logic [9:0]  wave_sample;
  logic        sample_valid, sq_out;

  dds_wave_core u0 (
    .clk(clk), .rst_n(rst_n), .ftw0_i(ftw0), .ftw1_i(ftw1),
    .poff0_i(po0), .poff1_i(po1), .hold_i(hold), .fsel_i(fsel),
    .psel_i(psel), .tri_mode_i(tri_m), .sq_en_i(sq_en), .sq_direct_i(sq_dir),
    .wave_sample(wave_sample), .sample_valid(sample_valid), .sq_out(sq_out)
  );

  int checks = 0;
  int fails  = 0;
  string sect = "R12";

  // behavioural reference state
  longint m_acc, m_ftw;
  int     m_sample, m_p, m_poff;
  bit     m_valid, m_sq, m_prev, m_tog, m_msb, m_bad, m_quiet;

  function automatic int sine_ref(int p);
    real a, s;
    int  mag;
    a   = 2.0 * 3.14159265358979 * (real'(p / 16) + 0.5) / 256.0;
    s   = $sin(a);
    mag = $rtoi(511.0 * (s < 0.0 ? -s : s) + 0.5);
    return (s >= 0.0) ? 512 + mag : 512 - mag;
  endfunction

  function automatic int tri_ref(int p);
    return (p < 2048) ? p / 2 : (4095 - p) / 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_sample = 0; m_valid = 0; m_sq = 0; m_prev = 0; m_tog = 0;
    end else begin
      m_ftw   = fsel ? longint'(ftw1) : longint'(ftw0);
      m_poff  = psel ? int'(po1) : int'(po0);
      m_bad   = m_ftw > (MOD / 2);
      m_quiet = hold || m_bad || (tri_m && sq_en);
      m_p     = (int'(m_acc / 65536) + m_poff) % 4096;
      m_msb   = (m_acc >= MOD / 2);
      if (hold) begin
        m_prev = 0; m_tog = 0; m_sq = 0;
      end else begin
        if (m_msb && !m_prev) m_tog = !m_tog;
        m_prev = m_msb;
        m_sq   = (sq_en && !m_quiet) ? (sq_dir ? m_msb : m_tog) : 1'b0;
      end
      m_sample = m_quiet ? 0 : (tri_m ? tri_ref(m_p) : sine_ref(m_p));
      m_valid  = !m_quiet;
      if (hold)        m_acc = 0;
      else if (!m_bad) m_acc = (m_acc + m_ftw) % MOD;
    end
  end

  task automatic compare();
    string tag;
    checks++;
    tag = tri_m ? "R6" : "R5";
    if (int'(wave_sample) != m_sample) begin
      fails++;
      $display("FAIL %s/%s sample: actual %0d expected %0d at %0t", sect, tag, wave_sample, m_sample, $time);
    end
    checks++;
    if (sample_valid != m_valid) begin
      fails++;
      $display("FAIL %s valid: actual %0d expected %0d at %0t", sect, sample_valid, m_valid, $time);
    end
    checks++;
    tag = !sq_en ? "R11" : (sq_dir ? "R7" : "R8");
    if (sq_out != m_sq) begin
      fails++;
      $display("FAIL %s/%s square: actual %0d expected %0d at %0t", sect, tag, sq_out, m_sq, $time);
    end
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; hold = 1; fsel = 0; psel = 0; tri_m = 0; sq_en = 0; sq_dir = 1;
    ftw0 = 28'h0123457; ftw1 = 28'h0040000; po0 = 12'd0; po1 = 12'd1024;
    // R12 reset state
    sect = "R12"; step(3);
    rst_n = 1;
    // R4 hold keeps everything quiet
    sect = "R4"; step(4);
    // R1 / R5 free-running sine
    hold = 0; sect = "R1"; step(300);
    sect = "R5"; ftw0 = 28'h0ABCDE1; step(200);
    // R2 frequency switch mid-run, phase continuous
    sect = "R2"; fsel = 1; step(50); fsel = 0; step(7); fsel = 1; step(30);
    // R3 phase select with wrap
    sect = "R3"; po0 = 12'd4095; psel = 0; step(40); psel = 1; step(40); psel = 0; step(5);
    // R6 triangle
    sect = "R6"; tri_m = 1; fsel = 0; ftw0 = 28'h0345679; step(300);
    // R7 square direct, select flips meeting top-bit edges
    sect = "R7"; tri_m = 0; sq_en = 1; sq_dir = 1; ftw0 = 28'h4000000; ftw1 = 28'h1000000;
    step(20); fsel = 1; step(13); fsel = 0; psel = 1; step(9);
    // R8 divide by two
    sect = "R8"; sq_dir = 0; step(40); fsel = 1; step(37); fsel = 0; step(11);
    // R9 reserved combination
    sect = "R9"; tri_m = 1; step(20); tri_m = 0; step(12);
    // R10 invalid word, then exact half rate
    sect = "R10"; ftw0 = 28'h8000001; step(15); ftw0 = 28'h8000000; step(15);
    // R11 square disabled
    sect = "R11"; sq_en = 0; ftw0 = 28'h0777777; step(40);
    // R4 hold mid-run, release together with a new word
    sect = "R4"; sq_en = 1; hold = 1; step(6); hold = 0; ftw0 = 28'h2000000; step(40);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule